// File: doc/BRIEF.md
# DREQ-Driven Single-Channel DMA Engine

This block is one DMA channel that copies data units from a source address to a destination address. A peripheral starts the work by raising a transfer request line. The channel then asks the CPU for the bus, waits for the grant, and moves each unit in two steps. First it reads the source and holds the returned word internally. Then it writes that held word to the destination.

Software sets up the channel through a small register port. It programs both addresses, a 16-bit unit count, the unit size and the stepping direction of each address. It also chooses one of three bus-hold policies:

- **Block:** one request moves a fixed number of units.
- **Continuation:** units keep moving while the request stays high.
- **Burst:** one request runs the whole count.

When the count runs out, the channel clears its own enable bit and sets a sticky completion flag. If software has allowed it, the flag drives the interrupt output.

The memory master port is a simple synchronous port. A read issued in one cycle returns `mem_rdata` in the next cycle. A write completes in the cycle it is issued. `mem_size` states the unit width, and the data travels in the low bytes of the data bus.

Top module: `dma_chan`

## Requirements
- R1: After reset, `bus_req`, `mem_req`, `dack` and `irq` are low, and every readable register reads zero.
- R2: Each unit reads from the source address, then writes the same data to the destination address two cycles later. During both accesses `mem_size` equals the programmed size: 0 means byte, 1 means half-word, 2 means word.
- R3: `bus_req` rises only when the channel is enabled (CTRL bit 0) and `dreq` is high while the channel is idle. No memory access happens while `bus_grant` is low.
- R4: Block mode (CTRL bits 2:1 = 0): each request moves exactly the number of units in CTRL bits 15:8 (0 means 256). After that, `bus_req` drops.
- R5: Continuation mode (CTRL bits 2:1 = 1): after each unit's write, another unit follows only if `dreq` is still high in that write cycle. Otherwise, or when the count ends, `bus_req` drops.
- R6: Burst mode (CTRL bits 2:1 = 2): a single `dreq` pulse runs every remaining unit without releasing the bus, whatever `dreq` does.
- R7: The count register (offset 2, 16 bits) decrements by one per unit and reads back the remaining count. A value of 0 stands for 65536 units.
- R8: After each unit, the source and destination registers (offsets 0 and 1) step by the unit size in bytes (1, 2 or 4). Each moves up, or down if its own direction bit is set (CTRL bit 5 for the source, bit 6 for the destination).
- R9: On the last unit, CTRL bit 0 clears and the status flag (offset 4, bit 0) sets. The flag stays set until software writes 1 to it. `irq` equals the flag ANDed with CTRL bit 7.
- R10: `dack` is high exactly in the cycles where a destination write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index: 0 source, 1 destination, 2 count, 3 control, 4 status |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| dreq | input | 1 | Peripheral transfer request |
| dack | output | 1 | Transfer acknowledge, high during a destination write |
| bus_req | output | 1 | Bus request to the CPU |
| bus_grant | input | 1 | Bus grant from the CPU |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | Access width: 0 byte, 1 half-word, 2 word |
| mem_wdata | output | 32 | Write data in the low bytes |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| irq | output | 1 | Completion interrupt |

## Verification
The copy path is swept over all three unit sizes and all four combinations of source and destination direction. Each run uses a burst transfer that is compared byte for byte against an arithmetically built image of memory. This separates errors in step size from errors in direction or byte lanes.

Block mode gets repeated request pulses, which show that the block length is counted apart from the total count. Continuation mode gets a request that drops in the middle of a run, which shows the release-on-low rule and the re-request that follows. A start from count 0 confirms that 0 wraps as 65536 rather than ending at once.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    MODE_BLOCK = 2'd0,
    MODE_CONT  = 2'd1,
    MODE_BURST = 2'd2,
    MODE_RSVD  = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RD,
    ST_LAT,
    ST_WR
  } state_e;

  // control register layout, LSB first: en, mode, size, src_dec, dst_dec, irq_en, blk_len
  typedef struct packed {
    logic [7:0] blk_len;
    logic       irq_en;
    logic       dst_dec;
    logic       src_dec;
    logic [1:0] size;
    mode_e      mode;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = 16;

  localparam logic [2:0] REG_SRC  = 3'd0;
  localparam logic [2:0] REG_DST  = 3'd1;
  localparam logic [2:0] REG_CNT  = 3'd2;
  localparam logic [2:0] REG_CTRL = 3'd3;
  localparam logic [2:0] REG_STAT = 3'd4;

endpackage

// File: rtl/dma_step.sv
module dma_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic          dec,
  output logic [AW-1:0] addr_next
);
  logic [AW-1:0] step;

  always_comb begin
    step      = AW'(1) << size;
    addr_next = dec ? (addr - step) : (addr + step);
  end
endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          unit_done,
  input  logic          fin,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q,
  output ctrl_t         ctrl_q,
  output logic          done_q
);
  localparam int NADDR = 2;

  logic [AW-1:0] addr_q    [NADDR];
  logic [AW-1:0] addr_d    [NADDR];
  logic [AW-1:0] addr_step [NADDR];
  logic          dec_sel   [NADDR];
  logic [CW-1:0] cnt_d;
  ctrl_t         ctrl_d;
  logic          done_d;

  assign dec_sel[0] = ctrl_q.src_dec;
  assign dec_sel[1] = ctrl_q.dst_dec;

  for (genvar i = 0; i < NADDR; i++) begin : g_addr
    dma_step #(.AW(AW)) i_step (
      .addr      (addr_q[i]),
      .size      (ctrl_q.size),
      .dec       (dec_sel[i]),
      .addr_next (addr_step[i])
    );

    always_comb begin
      addr_d[i] = addr_q[i];
      if (unit_done) begin
        addr_d[i] = addr_step[i];
      end else if (cfg_we && cfg_addr == 3'(i)) begin
        addr_d[i] = cfg_wdata[AW-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[i] <= '0;
      end else begin
        addr_q[i] <= addr_d[i];
      end
    end
  end

  assign src_q = addr_q[0];
  assign dst_q = addr_q[1];

  always_comb begin
    cnt_d  = cnt_q;
    ctrl_d = ctrl_q;
    done_d = done_q;

    if (unit_done) begin
      cnt_d = cnt_q - CW'(1);
    end else if (cfg_we && cfg_addr == REG_CNT) begin
      cnt_d = cfg_wdata[CW-1:0];
    end

    if (cfg_we && cfg_addr == REG_CTRL) begin
      ctrl_d = ctrl_t'(cfg_wdata[CTRL_W-1:0]);
    end
    if (fin) begin
      ctrl_d.en = 1'b0;
    end

    if (cfg_we && cfg_addr == REG_STAT && cfg_wdata[0]) begin
      done_d = 1'b0;
    end
    if (fin) begin
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ctrl_q <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      ctrl_q <= ctrl_d;
      done_q <= done_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      REG_SRC:  cfg_rdata[AW-1:0]     = addr_q[0];
      REG_DST:  cfg_rdata[AW-1:0]     = addr_q[1];
      REG_CNT:  cfg_rdata[CW-1:0]     = cnt_q;
      REG_CTRL: cfg_rdata[CTRL_W-1:0] = ctrl_q;
      REG_STAT: cfg_rdata[0]          = done_q;
      default:  cfg_rdata             = '0;
    endcase
  end

  assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |=> cnt_q == $past(cnt_q) - CW'(1));

  assert_fin_clears_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (!ctrl_q.en && done_q));

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!unit_done && !cfg_we) |=> ($stable(addr_q[0]) && $stable(addr_q[1])));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !cfg_we) |=> done_q);
endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
  import dma_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_t         ctrl,
  input  logic [CW-1:0] cnt,
  input  logic          dreq,
  input  logic          bus_grant,
  input  logic [DW-1:0] mem_rdata,
  output logic          bus_req,
  output logic          mem_req,
  output logic          mem_we,
  output logic          dack,
  output logic [DW-1:0] data_q,
  output logic          unit_done,
  output logic          fin
);
  localparam int BLW = $bits(ctrl.blk_len);

  state_e         state_q, state_d;
  logic [BLW-1:0] blk_q, blk_d;
  logic [DW-1:0]  data_d;
  logic           last_unit;
  logic           last_blk;

  assign last_unit = (cnt == CW'(1));
  assign last_blk  = (blk_q == BLW'(1));

  always_comb begin
    state_d   = state_q;
    blk_d     = blk_q;
    data_d    = data_q;
    unit_done = 1'b0;
    fin       = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (ctrl.en && dreq) begin
          state_d = ST_REQ;
        end
      end
      ST_REQ: begin
        if (bus_grant) begin
          state_d = ST_RD;
          blk_d   = ctrl.blk_len;
        end
      end
      ST_RD: begin
        state_d = ST_LAT;
      end
      ST_LAT: begin
        data_d  = mem_rdata;
        state_d = ST_WR;
      end
      ST_WR: begin
        unit_done = 1'b1;
        blk_d     = blk_q - BLW'(1);
        if (last_unit) begin
          fin     = 1'b1;
          state_d = ST_IDLE;
        end else begin
          case (ctrl.mode)
            MODE_BLOCK: state_d = last_blk ? ST_IDLE : ST_RD;
            MODE_CONT:  state_d = dreq ? ST_RD : ST_IDLE;
            default:    state_d = ST_RD;
          endcase
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      blk_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      blk_q   <= blk_d;
      data_q  <= data_d;
    end
  end

  assign bus_req = (state_q != ST_IDLE);
  assign mem_req = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we  = (state_q == ST_WR);
  assign dack    = (state_q == ST_WR);

  assert_mem_needs_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (bus_grant && bus_req));

  assert_write_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> $past(mem_req && !mem_we, 2));

  assert_burst_holds_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !fin && ctrl.mode == MODE_BURST) |=> bus_req);

  assert_req_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(ctrl.en && dreq));
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          dreq,
  output logic          dack,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          irq
);
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  ctrl_t         ctrl_q;
  logic          done_q;
  logic          unit_done, fin;
  logic [DW-1:0] data_q;

  dma_regs #(.AW(AW), .DW(DW), .CW(CW)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .unit_done (unit_done),
    .fin       (fin),
    .src_q     (src_q),
    .dst_q     (dst_q),
    .cnt_q     (cnt_q),
    .ctrl_q    (ctrl_q),
    .done_q    (done_q)
  );

  dma_fsm #(.DW(DW), .CW(CW)) i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl_q),
    .cnt       (cnt_q),
    .dreq      (dreq),
    .bus_grant (bus_grant),
    .mem_rdata (mem_rdata),
    .bus_req   (bus_req),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .dack      (dack),
    .data_q    (data_q),
    .unit_done (unit_done),
    .fin       (fin)
  );

  assign mem_addr  = mem_we ? dst_q : src_q;
  assign mem_size  = ctrl_q.size;
  assign mem_wdata = data_q;
  assign irq       = done_q && ctrl_q.irq_en;

  assert_irq_follows_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_q);
endmodule

// File: tb/test_dma_chan.sv
module test_dma_chan;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        dreq, dack, bus_req, bus_grant;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic        irq;

  int checks, failures;
  int wr_cnt, bad_grant, bad_dack;
  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];

  dma_chan i_dma_chan (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dreq(dreq), .dack(dack),
    .bus_req(bus_req), .bus_grant(bus_grant), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) bus_grant <= rst_n && bus_req;

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (b < (1 << mem_size)) mem[8'(mem_addr[7:0] + 8'(b))] = mem_wdata[8*b +: 8];
      end else begin
        for (int b = 0; b < 4; b++)
          mem_rdata[8*b +: 8] <= mem[8'(mem_addr[7:0] + 8'(b))];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_we) wr_cnt++;
      if (mem_req && !bus_grant) bad_grant++;
      if (dack != (mem_req && mem_we)) bad_dack++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  function automatic logic [31:0] ctrl_word(input bit en, input int mode, input int sz,
      input bit sd, input bit dd, input bit ie, input int blk);
    return {16'h0, 8'(blk), ie, dd, sd, 2'(sz), 2'(mode), en};
  endfunction

  task automatic init_mem();
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 8'(i * 5 + 1);
      ref_mem[i] = 8'(i * 5 + 1);
    end
  endtask

  task automatic build_ref(input int s0, input int d0, input int sz, input bit sd,
                           input bit dd, input int n);
    int step;
    step = 1 << sz;
    for (int k = 0; k < n; k++) begin
      int sa, da;
      sa = sd ? s0 - k*step : s0 + k*step;
      da = dd ? d0 - k*step : d0 + k*step;
      for (int b = 0; b < step; b++) ref_mem[(da + b) & 255] = ref_mem[(sa + b) & 255];
    end
  endtask

  task automatic cmp_mem(input string req);
    int bad;
    int first;
    bad = 0;
    first = 0;
    for (int i = 0; i < 256; i++)
      if (mem[i] !== ref_mem[i]) begin
        if (bad == 0) first = i;
        bad++;
      end
    chk(bad == 0, req, "memory image", longint'(mem[first]), longint'(ref_mem[first]));
  endtask

  task automatic pulse_dreq();
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int w0;
    checks = 0; failures = 0; wr_cnt = 0; bad_grant = 0; bad_dack = 0;
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; dreq = 0; rst_n = 0;
    init_mem();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    @(negedge clk);
    chk(!bus_req && !mem_req && !dack && !irq, "R1", "outputs after reset",
        {bus_req, mem_req, dack, irq}, 0);
    for (int a = 0; a < 5; a++) begin
      cfg_rd(3'(a), d);
      chk(d == 0, "R1", "register after reset", d, 0);
    end

    // R3 enabled but no request: bus stays idle
    cfg_wr(3'd2, 32'd2);
    cfg_wr(3'd3, ctrl_word(1, 2, 0, 0, 0, 0, 0));
    repeat (6) @(negedge clk);
    chk(!bus_req && wr_cnt == 0, "R3", "no request without dreq", bus_req, 0);
    // R3 request with grant still low: no memory access yet
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
    chk(bus_req && !mem_req, "R3", "bus_req before grant", {bus_req, mem_req}, 2'b10);
    repeat (20) @(negedge clk);
    cfg_wr(3'd4, 32'd1);

    // R2 R6 R7 R8 sweep over size and directions in burst mode
    for (int sz = 0; sz < 3; sz++)
      for (int sd = 0; sd < 2; sd++)
        for (int dd = 0; dd < 2; dd++) begin
          int s0, d0, step, n;
          n = 4;
          step = 1 << sz;
          s0 = sd ? 'h3C : 'h20;
          d0 = dd ? 'hBC : 'hA0;
          init_mem();
          build_ref(s0, d0, sz, sd, dd, n);
          cfg_wr(3'd0, 32'(s0));
          cfg_wr(3'd1, 32'(d0));
          cfg_wr(3'd2, 32'(n));
          cfg_wr(3'd3, ctrl_word(1, 2, sz, sd, dd, 1, 1));
          w0 = wr_cnt;
          pulse_dreq();
          repeat (40) @(negedge clk);
          cmp_mem("R2");
          chk(wr_cnt - w0 == n, "R6", "burst unit count", wr_cnt - w0, n);
          cfg_rd(3'd0, d);
          chk(d == 32'(sd ? s0 - n*step : s0 + n*step), "R8", "source end", d,
              32'(sd ? s0 - n*step : s0 + n*step));
          cfg_rd(3'd1, d);
          chk(d == 32'(dd ? d0 - n*step : d0 + n*step), "R8", "dest end", d,
              32'(dd ? d0 - n*step : d0 + n*step));
          cfg_rd(3'd2, d);
          chk(d == 0, "R7", "count end", d, 0);
          cfg_rd(3'd3, d);
          chk(d[0] == 0 && irq && !bus_req, "R9", "en cleared irq set", {d[0], irq}, 2'b01);
          cfg_wr(3'd4, 32'd1);
        end

    // R4 block mode: 3 words per request, 7 total
    init_mem();
    build_ref('h10, 'h80, 2, 0, 0, 7);
    cfg_wr(3'd0, 32'h10);
    cfg_wr(3'd1, 32'h80);
    cfg_wr(3'd2, 32'd7);
    cfg_wr(3'd3, ctrl_word(1, 0, 2, 0, 0, 1, 3));
    w0 = wr_cnt;
    pulse_dreq();
    repeat (30) @(negedge clk);
    chk(wr_cnt - w0 == 3 && !bus_req, "R4", "first block", wr_cnt - w0, 3);
    cfg_rd(3'd2, d);
    chk(d == 4, "R7", "count after block", d, 4);
    chk(!irq, "R9", "no irq mid run", irq, 0);
    pulse_dreq();
    repeat (30) @(negedge clk);
    chk(wr_cnt - w0 == 6 && !bus_req, "R4", "second block", wr_cnt - w0, 6);
    pulse_dreq();
    repeat (30) @(negedge clk);
    chk(wr_cnt - w0 == 7, "R4", "block cut by count end", wr_cnt - w0, 7);
    cmp_mem("R4");
    repeat (5) @(negedge clk);
    chk(irq, "R9", "irq sticky", irq, 1);
    cfg_rd(3'd4, d);
    chk(d == 1, "R9", "status flag", d, 1);
    cfg_wr(3'd4, 32'd1);
    @(negedge clk);
    chk(!irq, "R9", "irq cleared by write", irq, 0);

    // R5 R7 continuation from count 0 (65536), drop dreq during third write
    cfg_wr(3'd0, 32'h10);
    cfg_wr(3'd1, 32'h80);
    cfg_wr(3'd2, 32'd0);
    cfg_wr(3'd3, ctrl_word(1, 1, 0, 0, 0, 1, 1));
    w0 = wr_cnt;
    @(negedge clk); dreq = 1'b1;
    begin
      int k;
      k = 0;
      for (int t = 0; t < 100 && k < 3; t++) begin
        @(negedge clk);
        if (mem_req && mem_we) k++;
        if (k == 3) dreq = 1'b0;
      end
    end
    repeat (10) @(negedge clk);
    chk(wr_cnt - w0 == 3 && !bus_req, "R5", "release on dreq low", wr_cnt - w0, 3);
    cfg_rd(3'd2, d);
    chk(d == 32'hFFFD, "R7", "count 0 wraps as 65536", d, 32'hFFFD);
    cfg_rd(3'd4, d);
    chk(d == 0, "R9", "no completion mid run", d, 0);
    cfg_wr(3'd2, 32'd2);
    @(negedge clk); dreq = 1'b1;
    repeat (30) @(negedge clk);
    chk(wr_cnt - w0 == 5 && !bus_req, "R5", "release at count end with dreq high",
        wr_cnt - w0, 5);
    cfg_rd(3'd4, d);
    chk(d == 1 && irq, "R9", "completion in continuation", d, 1);
    dreq = 1'b0;

    chk(bad_grant == 0, "R3", "accesses without grant", bad_grant, 0);
    chk(bad_dack == 0, "R10", "dack vs write cycles", bad_dack, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule